// File: doc/BRIEF.md
# Interrupt Mode Qualifier and Vector Offset Generator

This unit sits beside the exception logic of a RISC core that has eight interrupt lines: six hardware lines on lines 7 to 2 and two software lines on lines 1 and 0. Each cycle it looks at the raw pending bits, the per-line enable mask and a handful of control fields: the vector-select bit, the boot-vector flag, a 5-bit vector spacing field, a flag saying vectored dispatch is built in, and a static strap saying an external interrupt controller is attached. From these it works out which dispatch mode is in force. It then finds the highest-priority enabled pending line and forms the exception offset that the fetch unit should jump to.

In the non-vectored (compatibility) mode the offset is one of two fixed values. In vectored mode each line gets its own handler slot, and the spacing field sets the slot size. In external-controller mode the unit does no prioritizing of its own and passes through a single request input. When the mask leaves no line eligible, the unit reports the condition as spurious instead of dispatching. All results come out of one register stage, so they always describe the same set of inputs.

Top module: `irqv_dispatch`

## Requirements
- R1: Compatibility mode (mode code 0) is reported whenever the vector-select bit is 0, the boot-vector flag is 1, or the spacing field is 0, whatever the other inputs are.
- R2: In compatibility mode the offset is 0x180 when the vector-select bit is 0 and 0x200 when it is 1.
- R3: Vectored mode (mode code 1) is reported when vectored-capable is 1, external-present is 0, spacing is nonzero, vector-select is 1 and boot-vector is 0.
- R4: In vectored mode with an eligible line, the offset is 0x200 + line × spacing × 32.
- R5: When no compatibility condition holds and external-present is 1, the mode is external (mode code 2). The request flag then equals the external request input, the line is 0, the offset is 0x200, spurious is 0, and the pending and mask bits have no effect.
- R6: A line is eligible only when both its pending bit and its mask bit are 1. In modes 0 and 1 with no eligible line, the request flag is 0, spurious is 1, the line is 0 and the offset is that mode's base (0x180 or 0x200 as in R2, 0x200 in vectored mode).
- R7: With several eligible lines, the highest-numbered one is reported (line 7 highest, line 0 lowest).
- R8: Every output reflects the inputs sampled at the previous rising clock edge, and all outputs change together.
- R9: While reset (active low, synchronous) is applied, the outputs are mode 0, request 0, spurious 0, line 0 and offset 0x180.
- R10: If vectored-capable is 0 and external-present is 0, the unit stays in compatibility mode even when vector-select is 1, boot-vector is 0 and spacing is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | 8 | Raw pending bits, one per line |
| mask_i | input | 8 | Per-line enable mask |
| vsel_i | input | 1 | Vector-select bit (0: general offset) |
| boot_vec_i | input | 1 | Boot-vector flag, forces compatibility mode |
| spacing_i | input | 5 | Vector spacing in 32-byte units |
| vec_cap_i | input | 1 | Vectored dispatch is implemented |
| ext_present_i | input | 1 | Static strap: external controller attached |
| ext_req_i | input | 1 | Request from the external controller |
| irq_o | output | 1 | Dispatch request |
| spurious_o | output | 1 | Nothing eligible in an internal mode |
| line_o | output | 3 | Selected line number |
| mode_o | output | 2 | 0 compatibility, 1 vectored, 2 external |
| offset_o | output | 13 | Exception offset to fetch from |

## Verification
All results are due exactly one rising edge after the inputs are applied. Inputs change on the falling edge, and every result is read at the following falling edge, after a single register update. A directed latency test also reads the outputs right after an input change, before any rising edge, to confirm that they still show the earlier inputs. The reset values are read at a falling edge while reset is held, both at start-up and again when reset is applied in the middle of live traffic.

// File: rtl/irqv_pkg.sv
// Package: shared mode encoding for the interrupt dispatch unit.
// Assumes the encoding is consumed as a raw 2-bit code at the top ports.
package irqv_pkg;
    typedef enum logic [1:0] {
        MODE_COMPAT = 2'd0,
        MODE_VEC    = 2'd1,
        MODE_EXT    = 2'd2
    } irq_mode_e;
endpackage

// File: rtl/irqv_mode_qual.sv
// Module: irqv_mode_qual
// Decides which dispatch mode the control fields select. Compatibility
// conditions dominate; then the external strap; then vectored if built in.
// Assumes ext_present is a static strap (no glitch handling needed).
module irqv_mode_qual #(
    parameter int SPC_W = 5
) (
    input  logic                vsel,
    input  logic                boot_vec,
    input  logic [SPC_W-1:0]    spacing,
    input  logic                vec_cap,
    input  logic                ext_present,
    output irqv_pkg::irq_mode_e mode
);
    import irqv_pkg::*;

    logic force_compat;

    // Any one of these holds the core in non-vectored dispatch.
    assign force_compat = !vsel || boot_vec || (spacing == '0);

    // Mode priority: forced compatibility, external, vectored, fallback.
    always_comb begin
        if (force_compat)      mode = MODE_COMPAT;
        else if (ext_present)  mode = MODE_EXT;
        else if (vec_cap)      mode = MODE_VEC;
        else                   mode = MODE_COMPAT;
    end
endmodule

// File: rtl/irqv_prio_enc.sv
// Module: irqv_prio_enc
// Masks pending lines and picks the highest-numbered eligible one.
// Assumes line NUM_LINES-1 has the highest fixed priority.
module irqv_prio_enc #(
    parameter int NUM_LINES = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    output logic                 any,
    output logic [LINE_W-1:0]    line
);
    logic [NUM_LINES-1:0] elig;

    // One AND gate per line: eligible only if pending and enabled.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_elig
        assign elig[g] = pend[g] & mask[g];
    end

    // Scan upward so the highest eligible index is the one kept.
    always_comb begin
        line = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i]) line = LINE_W'(i);
        end
    end

    // Flag that at least one line qualified.
    assign any = |elig;
endmodule

// File: rtl/irqv_offset_gen.sv
// Module: irqv_offset_gen
// Forms the fetch offset from the mode, the selected line and the spacing.
// Assumes the caller zeroes the line when nothing is eligible.
module irqv_offset_gen #(
    parameter int NUM_LINES  = 8,
    parameter int SPC_W      = 5,
    parameter int OFF_W      = 13,
    parameter int GEN_OFF    = 'h180,
    parameter int INT_OFF    = 'h200,
    parameter int SLOT_UNIT  = 32,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int SLOT_SH   = $clog2(SLOT_UNIT)
) (
    input  irqv_pkg::irq_mode_e mode,
    input  logic                vsel,
    input  logic [LINE_W-1:0]   line,
    input  logic [SPC_W-1:0]    spacing,
    output logic [OFF_W-1:0]    offset
);
    import irqv_pkg::*;

    logic [OFF_W-1:0] slot_bytes;
    logic [OFF_W-1:0] vec_off;

    // Handler slot size in bytes.
    assign slot_bytes = OFF_W'(spacing) << SLOT_SH;

    // Per-line vectored target relative to the exception base.
    assign vec_off = OFF_W'(INT_OFF) + OFF_W'(line) * slot_bytes;

    // Select the offset the active mode calls for.
    always_comb begin
        unique case (mode)
            MODE_VEC: offset = vec_off;
            MODE_EXT: offset = OFF_W'(INT_OFF);
            default:  offset = vsel ? OFF_W'(INT_OFF) : OFF_W'(GEN_OFF);
        endcase
    end
endmodule

// File: rtl/irqv_dispatch.sv
// Module: irqv_dispatch (top)
// Qualifies the interrupt mode, prioritizes eligible lines, builds the
// exception offset and registers every result in one stage.
// Assumes synchronous active-low reset and a static external strap.
module irqv_dispatch #(
    parameter int NUM_LINES = 8,
    parameter int SPC_W     = 5,
    parameter int OFF_W     = 13,
    parameter int GEN_OFF   = 'h180,
    parameter int INT_OFF   = 'h200,
    parameter int SLOT_UNIT = 32,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int SLOT_SH  = $clog2(SLOT_UNIT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic                 vsel_i,
    input  logic                 boot_vec_i,
    input  logic [SPC_W-1:0]     spacing_i,
    input  logic                 vec_cap_i,
    input  logic                 ext_present_i,
    input  logic                 ext_req_i,
    output logic                 irq_o,
    output logic                 spurious_o,
    output logic [LINE_W-1:0]    line_o,
    output logic [1:0]           mode_o,
    output logic [OFF_W-1:0]     offset_o
);
    import irqv_pkg::*;

    irq_mode_e         mode_c;
    logic              any_c;
    logic [LINE_W-1:0] enc_line_c;
    logic [LINE_W-1:0] line_c;
    logic [OFF_W-1:0]  offset_c;
    logic              irq_c;
    logic              spur_c;

    irqv_mode_qual #(.SPC_W(SPC_W)) u_qual (
        .vsel        (vsel_i),
        .boot_vec    (boot_vec_i),
        .spacing     (spacing_i),
        .vec_cap     (vec_cap_i),
        .ext_present (ext_present_i),
        .mode        (mode_c)
    );

    irqv_prio_enc #(.NUM_LINES(NUM_LINES)) u_prio (
        .pend (pend_i),
        .mask (mask_i),
        .any  (any_c),
        .line (enc_line_c)
    );

    // External mode ignores the local encoder; idle requests report line 0.
    assign line_c = (mode_c == MODE_EXT || !any_c) ? '0 : enc_line_c;

    irqv_offset_gen #(
        .NUM_LINES (NUM_LINES),
        .SPC_W     (SPC_W),
        .OFF_W     (OFF_W),
        .GEN_OFF   (GEN_OFF),
        .INT_OFF   (INT_OFF),
        .SLOT_UNIT (SLOT_UNIT)
    ) u_off (
        .mode    (mode_c),
        .vsel    (vsel_i),
        .line    (line_c),
        .spacing (spacing_i),
        .offset  (offset_c)
    );

    // Request and spurious flags; the external path bypasses masking.
    always_comb begin
        if (mode_c == MODE_EXT) begin
            irq_c  = ext_req_i;
            spur_c = 1'b0;
        end else begin
            irq_c  = any_c;
            spur_c = !any_c;
        end
    end

    // Single output register so all results describe the same inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o      <= 1'b0;
            spurious_o <= 1'b0;
            line_o     <= '0;
            mode_o     <= MODE_COMPAT;
            offset_o   <= OFF_W'(GEN_OFF);
        end else begin
            irq_o      <= irq_c;
            spurious_o <= spur_c;
            line_o     <= line_c;
            mode_o     <= mode_c;
            offset_o   <= offset_c;
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 2'd0 && !irq_o && !spurious_o && line_o == '0
                    && offset_o == OFF_W'(GEN_OFF))); // R9

    AST_COMPAT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsel_i || boot_vec_i || spacing_i == '0) |=> (mode_o == 2'd0)); // R1

    AST_GENERAL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        !vsel_i |=> (offset_o == OFF_W'(GEN_OFF))); // R2

    AST_VEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_cap_i && !ext_present_i && spacing_i != '0 && vsel_i && !boot_vec_i)
        |=> (mode_o == 2'd1)); // R3

    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && irq_o) |->
        (offset_o == OFF_W'(INT_OFF)
            + OFF_W'(line_o) * (OFF_W'($past(spacing_i)) << SLOT_SH))); // R4

    AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_present_i && vsel_i && !boot_vec_i && spacing_i != '0)
        |=> (mode_o == 2'd2 && irq_o == $past(ext_req_i) && !spurious_o)); // R5

    AST_LINE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && mode_o != 2'd2) |->
        (($past(pend_i) & $past(mask_i)) >> line_o) == NUM_LINES'(1)); // R7

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && spurious_o)); // R6

    AST_NOCAP_COMPAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_cap_i && !ext_present_i) |=> (mode_o == 2'd0)); // R10
endmodule

// File: tb/sim_irqv_dispatch.sv
module sim_irqv_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pend_i = '0, mask_i = '0;
    logic        vsel_i = 1'b0, boot_vec_i = 1'b0, vec_cap_i = 1'b0;
    logic        ext_present_i = 1'b0, ext_req_i = 1'b0;
    logic [4:0]  spacing_i = '0;
    logic        irq_o, spurious_o;
    logic [2:0]  line_o;
    logic [1:0]  mode_o;
    logic [12:0] offset_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irqv_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
        .vsel_i(vsel_i), .boot_vec_i(boot_vec_i), .spacing_i(spacing_i),
        .vec_cap_i(vec_cap_i), .ext_present_i(ext_present_i),
        .ext_req_i(ext_req_i), .irq_o(irq_o), .spurious_o(spurious_o),
        .line_o(line_o), .mode_o(mode_o), .offset_o(offset_o)
    );

    // Entry: pend,mask,vsel,bev,spc,cap,ext,ereq | irq,spur,line,mode,off
    localparam int NV = 15;
    localparam logic [45:0] TBL [NV] = '{
        {8'hFF,8'h0F,1'b0,1'b0,5'd1,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd3,2'd0,13'h180}, // R2 vsel 0
        {8'h81,8'hFF,1'b1,1'b1,5'd4,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd7,2'd0,13'h200}, // R1 boot flag
        {8'h04,8'h04,1'b1,1'b0,5'd0,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd2,2'd0,13'h200}, // R1 spacing 0
        {8'h24,8'hFF,1'b1,1'b0,5'd1,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd5,2'd1,13'h2A0}, // R4 spc1
        {8'h80,8'h80,1'b1,1'b0,5'd16,1'b1,1'b0,1'b0,1'b1,1'b0,3'd7,2'd1,13'h1000},// R4 spc16
        {8'h01,8'h01,1'b1,1'b0,5'd2,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd0,2'd1,13'h200}, // R4 line 0
        {8'h0B,8'h0E,1'b1,1'b0,5'd8,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd3,2'd1,13'h500}, // R6 mask
        {8'hF0,8'h0F,1'b1,1'b0,5'd4,1'b1,1'b0,1'b0, 1'b0,1'b1,3'd0,2'd1,13'h200}, // R6 vec spur
        {8'h00,8'hFF,1'b0,1'b0,5'd4,1'b1,1'b0,1'b0, 1'b0,1'b1,3'd0,2'd0,13'h180}, // R6 cmp spur
        {8'hFF,8'hFF,1'b1,1'b0,5'd1,1'b1,1'b1,1'b1, 1'b1,1'b0,3'd0,2'd2,13'h200}, // R5 ext req
        {8'hFF,8'hFF,1'b1,1'b0,5'd1,1'b1,1'b1,1'b0, 1'b0,1'b0,3'd0,2'd2,13'h200}, // R5 ignore
        {8'h00,8'h00,1'b1,1'b0,5'd2,1'b0,1'b1,1'b1, 1'b1,1'b0,3'd0,2'd2,13'h200}, // R5 no cap
        {8'h02,8'h02,1'b1,1'b1,5'd1,1'b1,1'b1,1'b0, 1'b1,1'b0,3'd1,2'd0,13'h200}, // R1 over ext
        {8'h40,8'h40,1'b1,1'b0,5'd1,1'b0,1'b0,1'b0, 1'b1,1'b0,3'd6,2'd0,13'h200}, // R10
        {8'hFF,8'h7F,1'b1,1'b0,5'd4,1'b1,1'b0,1'b0, 1'b1,1'b0,3'd6,2'd1,13'h500}  // R7
    };

    function automatic string tag_of(int i);
        case (i)
            0:        return "R2";
            1, 2, 12: return "R1";
            3, 4, 5:  return "R4";
            6, 7, 8:  return "R6";
            9, 10, 11: return "R5";
            13:       return "R10";
            default:  return "R7";
        endcase
    endfunction

    task automatic apply(input logic [45:0] v);
        pend_i = v[45:38]; mask_i = v[37:30]; vsel_i = v[29];
        boot_vec_i = v[28]; spacing_i = v[27:23]; vec_cap_i = v[22];
        ext_present_i = v[21]; ext_req_i = v[20];
    endtask

    task automatic check_out(input string tag, input logic [19:0] exp);
        logic [19:0] act;
        act = {irq_o, spurious_o, line_o, mode_o, offset_o};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: irq,spur,line,mode,off act=%0h/%0h/%0d/%0d/%0h exp=%0h/%0h/%0d/%0d/%0h",
                     tag, act[19], act[18], act[17:15], act[14:13], act[12:0],
                     exp[19], exp[18], exp[17:15], exp[14:13], exp[12:0]);
        end
    endtask

    localparam logic [19:0] RST_EXP = {1'b0, 1'b0, 3'd0, 2'd0, 13'h180};

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state at start-up
        repeat (3) @(negedge clk);
        check_out("R9", RST_EXP);
        rst_n = 1'b1;

        // Table walk: drive on falling edge, read one rising edge later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            @(negedge clk);
            check_out(tag_of(i), TBL[i][19:0]);
        end

        // R8: outputs hold the old result until the next rising edge
        @(negedge clk);
        apply(TBL[3]);
        @(negedge clk);
        apply(TBL[4]);
        #1;
        check_out("R8", TBL[3][19:0]);
        @(negedge clk);
        check_out("R8", TBL[4][19:0]);

        // R5: ext request toggles with pend/mask cleared, twice in a row
        @(negedge clk);
        apply(TBL[9]); pend_i = 8'h00; mask_i = 8'h00;
        @(negedge clk);
        check_out("R5", TBL[9][19:0]);
        ext_req_i = 1'b0;
        @(negedge clk);
        check_out("R5", TBL[10][19:0]);

        // R9: reset applied mid-traffic overrides live inputs
        apply(TBL[4]);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R9", RST_EXP);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R4", TBL[4][19:0]);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule